// File: doc/BRIEF.md
# Video Scanner Fetch Address Generator

This block works out which display-memory byte the video scanner is fetching during the current CPU cycle. A read from an unconnected I/O location can then return that byte, as a bus left floating would. A frame counter restarts on a frame-start pulse and advances once per CPU cycle strobe. The counter is held as a horizontal tick and a line number, with 65 ticks to a line.

The tick and the line become horizontal and vertical scanner counters. The vertical counter carries a fixed offset. The two counters are then folded into an interleaved memory address. A small adder scrambles the row bits into the address, and the display mode flags choose the page and region: text or low-resolution, or high-resolution graphics.

The address is registered and is valid one clock after the strobe. It always points into main RAM. The byte read back from RAM is passed straight through to the read-data output.

Top module: `scan_fetch_addr`

## Requirements
- R1: While `rst_n` is low, and after its release until the first strobe, `fetch_addr` is 0 and `fetch_valid` is 0. The frame count restarts at 0.
- R2: A high `frame_start` clears the frame count to 0 and takes priority over `cyc_en`. On that clock no address is captured. Each clock with `cyc_en` high and `frame_start` low advances the count by one. For count N, the tick is N mod 65 and the line is N / 65.
- R3: The horizontal counter is the tick minus one. On tick 0 it is 0 instead, so it reads 0 on both tick 0 and tick 1.
- R4: The vertical counter is the line plus 250 (0xFA), kept to 8 bits.
- R5: Address bits 9:7 hold vcount[5:3]. Bits 6:3 hold S, and bits 2:0 hold hcount[2:0]. S is the low 4 bits of 13 + hcount[5:3] + {vcount[7:6], vcount[7:6]}.
- R6: Text-like fetch applies when text mode is on or high-resolution mode is off. The fetch reads the second page when page2 is on and store80 is off. In text-like fetch, bit 10 is set for the first page and bit 11 for the second page, and bits 15:12 are 0.
- R7: Graphics fetch applies when text mode is off and high-resolution mode is on. Bit 13 is set for the first page and bit 14 for the second page. Bits 12:10 hold vcount[2:0].
- R8: Address bit 15 is always 0, so the fetch targets only the lower 32 KiB of main RAM.
- R9: A strobe captures the address for the count held before that strobe. The address appears, with `fetch_valid` high, on the next clock. Without a capture the address holds, even when mode inputs change, and `fetch_valid` is low.
- R10: `float_data` equals `ram_rdata` with no delay.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cyc_en | input | 1 | CPU cycle strobe |
| frame_start | input | 1 | Restarts the frame count |
| mode_text | input | 1 | Text display mode |
| mode_hires | input | 1 | High-resolution graphics mode |
| mode_page2 | input | 1 | Second display page selected |
| mode_store80 | input | 1 | Store80 mode; disables page selection for the fetch |
| ram_rdata | input | 8 | Byte read from main RAM at `fetch_addr` |
| fetch_addr | output | 16 | Registered scanner fetch address |
| fetch_valid | output | 1 | Pulses for one clock after each capture |
| float_data | output | 8 | Floating-bus read data |

## Verification
The hardest states to reach are the high lines, where vcount[7:6] becomes 0 after the offset wraps. The row-scramble term changes there. The line boundary, where the tick rolls over, is similar. Both need hundreds of strobes after a frame start. The stimulus reaches them by restarting the frame and holding the strobe high for a computed number of cycles. It then sweeps more than one full run of lines, comparing each captured address against a model built from the requirements. The strobe colliding with a frame start is forced directly, with the count parked at a nonzero tick.

// File: rtl/scan_pkg.sv
package scan_pkg;

    localparam int ADDR_W = 16;

    typedef struct packed {
        logic text;
        logic hires;
        logic page2;
        logic store80;
    } scan_mode_t;

endpackage

// File: rtl/scan_beam_ctr.sv
module scan_beam_ctr #(
    parameter int LINE_CYCLES = 65,
    parameter int LINE_W      = 9,
    localparam int TICK_W     = $clog2(LINE_CYCLES)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              frame_start,
    input  logic              cyc_en,
    output logic [TICK_W-1:0] tick,
    output logic [LINE_W-1:0] line
);

    localparam logic [TICK_W-1:0] TICK_LAST = TICK_W'(LINE_CYCLES - 1);

    typedef struct packed {
        logic [TICK_W-1:0] tick;
        logic [LINE_W-1:0] line;
    } beam_t;

    beam_t beam_d, beam_q;

    always_comb begin
        beam_d = beam_q;
        if (frame_start) begin
            beam_d = '0;
        end else if (cyc_en) begin
            if (beam_q.tick == TICK_LAST) begin
                beam_d.tick = '0;
                beam_d.line = beam_q.line + 1'b1;
            end else begin
                beam_d.tick = beam_q.tick + 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) beam_q <= '0;
        else        beam_q <= beam_d;
    end

    assign tick = beam_q.tick;
    assign line = beam_q.line;

    // R2: tick never leaves the line
    p_tick_range_r2: assert property (@(posedge clk) disable iff (!rst_n)
        tick <= TICK_LAST);

    // R2: frame start restarts the count
    p_frame_clear_r2: assert property (@(posedge clk) disable iff (!rst_n)
        frame_start |=> (tick == '0) && (line == '0));

    // R2: strobe inside a line steps the tick, line unchanged
    p_tick_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (cyc_en && !frame_start && tick != TICK_LAST)
        |=> (tick == $past(tick) + 1'b1) && (line == $past(line)));

    // R2: strobe at the last tick rolls into the next line
    p_line_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (cyc_en && !frame_start && tick == TICK_LAST)
        |=> (tick == '0) && (line == $past(line) + 1'b1));

    // R2: no strobe, no movement
    p_idle_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (!cyc_en && !frame_start) |=> $stable(tick) && $stable(line));

endmodule

// File: rtl/scan_hv_map.sv
module scan_hv_map #(
    parameter int TICK_W   = 7,
    parameter int LINE_W   = 9,
    parameter int HC_W     = 6,
    parameter int VC_W     = 8,
    parameter int V_OFFSET = 'hFA
) (
    input  logic [TICK_W-1:0] tick,
    input  logic [LINE_W-1:0] line,
    output logic [HC_W-1:0]   hcount,
    output logic [VC_W-1:0]   vcount
);

    localparam logic [LINE_W-1:0] V_OFS = LINE_W'(V_OFFSET);

    logic [TICK_W-1:0] tick_m1;
    logic [LINE_W-1:0] line_ofs;

    always_comb begin
        tick_m1  = tick - 1'b1;
        // the counter reads zero on the first two ticks of a line
        hcount   = (tick == '0) ? '0 : HC_W'(tick_m1);
        line_ofs = line + V_OFS;
        vcount   = VC_W'(line_ofs);
    end

endmodule

// File: rtl/scan_addr_fold.sv
module scan_addr_fold
    import scan_pkg::*;
#(
    parameter int HC_W     = 6,
    parameter int VC_W     = 8,
    parameter int ROW_BIAS = 'hD
) (
    input  logic [HC_W-1:0]   hcount,
    input  logic [VC_W-1:0]   vcount,
    input  scan_mode_t        mode,
    output logic [ADDR_W-1:0] addr
);

    localparam logic [3:0] BIAS = 4'(ROW_BIAS);

    logic [3:0] row_mix;
    logic [3:0] row_sum;
    logic [9:0] base;
    logic       alt_page;
    logic       graphics;

    always_comb begin
        row_mix  = {vcount[7:6], vcount[7:6]};
        row_sum  = BIAS + {1'b0, hcount[5:3]} + row_mix;
        base     = {vcount[5:3], row_sum, hcount[2:0]};
        alt_page = mode.page2 & ~mode.store80;
        graphics = ~mode.text & mode.hires;
        if (graphics)
            addr = {1'b0, alt_page, ~alt_page, vcount[2:0], base};
        else
            addr = {4'b0000, alt_page, ~alt_page, base};
    end

endmodule

// File: rtl/scan_fetch_addr.sv
module scan_fetch_addr
    import scan_pkg::*;
#(
    parameter int LINE_CYCLES = 65,
    parameter int LINE_W      = 9,
    parameter int HC_W        = 6,
    parameter int VC_W        = 8,
    parameter int V_OFFSET    = 'hFA,
    parameter int ROW_BIAS    = 'hD
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        cyc_en,
    input  logic        frame_start,
    input  logic        mode_text,
    input  logic        mode_hires,
    input  logic        mode_page2,
    input  logic        mode_store80,
    input  logic [7:0]  ram_rdata,
    output logic [15:0] fetch_addr,
    output logic        fetch_valid,
    output logic [7:0]  float_data
);

    localparam int TICK_W = $clog2(LINE_CYCLES);

    typedef struct packed {
        logic [ADDR_W-1:0] addr;
        logic              valid;
    } out_t;

    logic [TICK_W-1:0] tick;
    logic [LINE_W-1:0] line;
    logic [HC_W-1:0]   hcount;
    logic [VC_W-1:0]   vcount;
    logic [ADDR_W-1:0] fold_addr;
    scan_mode_t        mode;
    logic              capture;
    out_t              out_d, out_q;

    assign mode    = '{text: mode_text, hires: mode_hires,
                       page2: mode_page2, store80: mode_store80};
    assign capture = cyc_en & ~frame_start;

    scan_beam_ctr #(
        .LINE_CYCLES (LINE_CYCLES),
        .LINE_W      (LINE_W)
    ) i_beam (
        .clk         (clk),
        .rst_n       (rst_n),
        .frame_start (frame_start),
        .cyc_en      (cyc_en),
        .tick        (tick),
        .line        (line)
    );

    scan_hv_map #(
        .TICK_W   (TICK_W),
        .LINE_W   (LINE_W),
        .HC_W     (HC_W),
        .VC_W     (VC_W),
        .V_OFFSET (V_OFFSET)
    ) i_hv (
        .tick   (tick),
        .line   (line),
        .hcount (hcount),
        .vcount (vcount)
    );

    scan_addr_fold #(
        .HC_W     (HC_W),
        .VC_W     (VC_W),
        .ROW_BIAS (ROW_BIAS)
    ) i_fold (
        .hcount (hcount),
        .vcount (vcount),
        .mode   (mode),
        .addr   (fold_addr)
    );

    always_comb begin
        out_d       = out_q;
        out_d.valid = capture;
        if (capture) out_d.addr = fold_addr;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) out_q <= '0;
        else        out_q <= out_d;
    end

    assign fetch_addr  = out_q.addr;
    assign fetch_valid = out_q.valid;
    assign float_data  = ram_rdata;

    // R9: a capture raises valid on the next clock
    p_valid_follow_r9: assert property (@(posedge clk) disable iff (!rst_n)
        capture |=> fetch_valid);

    // R9: without a capture the address holds and valid is low
    p_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !capture |=> $stable(fetch_addr) && !fetch_valid);

    // R6: text-like fetch sets exactly one of bits 10/11, upper bits clear
    p_text_page_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_text || !mode_hires)
        |-> (fold_addr[15:12] == 4'b0000) && $onehot(fold_addr[11:10]));

    // R7: graphics fetch sets exactly one of bits 13/14
    p_gfx_page_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (!mode_text && mode_hires) |-> $onehot(fold_addr[14:13]));

    // R8: the fetch stays in the lower half of main RAM
    p_main_ram_r8: assert property (@(posedge clk) disable iff (!rst_n)
        fetch_addr[15] == 1'b0);

endmodule

// File: tb/test_scan_fetch_addr.sv
module test_scan_fetch_addr;

    localparam time CLK_P = 4ns;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cyc_en = 1'b0;
    logic        frame_start = 1'b0;
    logic        mode_text = 1'b1;
    logic        mode_hires = 1'b0;
    logic        mode_page2 = 1'b0;
    logic        mode_store80 = 1'b0;
    logic [7:0]  ram_rdata = 8'h00;
    logic [15:0] fetch_addr;
    logic        fetch_valid;
    logic [7:0]  float_data;

    int n_run  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    always #(CLK_P/2) clk = ~clk;

    scan_fetch_addr i_scan_fetch_addr (
        .clk          (clk),
        .rst_n        (rst_n),
        .cyc_en       (cyc_en),
        .frame_start  (frame_start),
        .mode_text    (mode_text),
        .mode_hires   (mode_hires),
        .mode_page2   (mode_page2),
        .mode_store80 (mode_store80),
        .ram_rdata    (ram_rdata),
        .fetch_addr   (fetch_addr),
        .fetch_valid  (fetch_valid),
        .float_data   (float_data)
    );

    // vector: count[15:0], text, hires, page2, store80, expected[15:0]
    localparam int NV = 15;
    localparam logic [35:0] VEC [NV] = '{
        {16'd0,   4'b1000, 16'h07E0},
        {16'd1,   4'b1000, 16'h07E0},
        {16'd2,   4'b1000, 16'h07E1},
        {16'd64,  4'b1000, 16'h079F},
        {16'd65,  4'b1000, 16'h07E0},
        {16'd65,  4'b0100, 16'h2FE0},
        {16'd0,   4'b0100, 16'h2BE0},
        {16'd390, 4'b1010, 16'h0868},
        {16'd390, 4'b1011, 16'h0468},
        {16'd390, 4'b0010, 16'h0868},
        {16'd0,   4'b0110, 16'h4BE0},
        {16'd0,   4'b0111, 16'h2BE0},
        {16'd0,   4'b1100, 16'h07E0},
        {16'd399, 4'b1000, 16'h0470},
        {16'd390, 4'b0100, 16'h2068}
    };

    task automatic check(input string req, input logic [15:0] got, input logic [15:0] exp);
        n_run++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s: got %h expected %h", req, got, exp);
        end
    endtask

    task automatic restart();
        frame_start = 1'b1;
        @(negedge clk);
        frame_start = 1'b0;
    endtask

    task automatic advance(input int n);
        cyc_en = 1'b1;
        repeat (n) @(negedge clk);
        cyc_en = 1'b0;
    endtask

    function automatic logic [15:0] ref_addr(input int n, input bit t, input bit h,
                                             input bit p2, input bit s80);
        int tk, ln, hc, vc, sm, bs, a;
        bit alt;
        tk  = n % 65;
        ln  = n / 65;
        hc  = (tk == 0) ? 0 : tk - 1;
        vc  = (ln + 250) % 256;
        sm  = (13 + ((hc >> 3) & 7) + (((vc >> 6) & 3) * 5)) % 16;
        bs  = (((vc >> 3) & 7) << 7) | (sm << 3) | (hc & 7);
        alt = p2 && !s80;
        if (!t && h) a = bs | (alt ? 16'h4000 : 16'h2000) | ((vc & 7) << 10);
        else         a = bs | (alt ? 16'h0800 : 16'h0400);
        return a[15:0];
    endfunction

    initial begin
        #(CLK_P * 200000);
        if (!done) begin
            n_run++;
            n_fail++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1: reset values while held
        check("R1 addr in reset", fetch_addr, 16'h0000);
        check("R1 valid in reset", {15'd0, fetch_valid}, 16'h0000);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 addr after release", fetch_addr, 16'h0000);

        // R10: read data passthrough
        ram_rdata = 8'hA5;
        #1;
        check("R10 passthrough A5", {8'h00, float_data}, 16'h00A5);
        ram_rdata = 8'h3C;
        #1;
        check("R10 passthrough 3C", {8'h00, float_data}, 16'h003C);
        @(negedge clk);

        // table walk: R3 R4 R5 R6 R7
        for (int i = 0; i < NV; i++) begin
            {mode_text, mode_hires, mode_page2, mode_store80} = VEC[i][19:16];
            restart();
            advance(int'(VEC[i][35:20]) + 1);
            check($sformatf("R3 R4 R5 R6 R7 vector %0d", i), fetch_addr, VEC[i][15:0]);
        end

        // R9: one strobe gives one valid pulse, then hold through mode change
        {mode_text, mode_hires, mode_page2, mode_store80} = 4'b1000;
        restart();
        advance(1);
        check("R9 valid after strobe", {15'd0, fetch_valid}, 16'h0001);
        check("R9 addr after strobe", fetch_addr, 16'h07E0);
        mode_hires = 1'b1; mode_text = 1'b0; mode_page2 = 1'b1;
        @(negedge clk);
        check("R9 valid drops", {15'd0, fetch_valid}, 16'h0000);
        check("R9 addr holds on mode change", fetch_addr, 16'h07E0);

        // R2: frame start beats a simultaneous strobe
        {mode_text, mode_hires, mode_page2, mode_store80} = 4'b1000;
        restart();
        advance(3);
        check("R2 parked at count 2", fetch_addr, 16'h07E1);
        cyc_en = 1'b1; frame_start = 1'b1;
        @(negedge clk);
        cyc_en = 1'b0; frame_start = 1'b0;
        check("R2 no capture on collision", {15'd0, fetch_valid}, 16'h0000);
        check("R2 addr held on collision", fetch_addr, 16'h07E1);
        advance(1);
        check("R2 count restarted", fetch_addr, 16'h07E0);

        // R8 R4 R5: sweep past the vertical wrap in graphics page 2
        {mode_text, mode_hires, mode_page2, mode_store80} = 4'b0110;
        restart();
        cyc_en = 1'b1;
        for (int k = 0; k < 700; k++) begin
            @(negedge clk);
            check($sformatf("R4 R5 R7 sweep %0d", k), fetch_addr, ref_addr(k, 0, 1, 1, 0));
            check("R8 bit15", {15'd0, fetch_addr[15]}, 16'h0000);
        end
        cyc_en = 1'b0;

        // R1: reset again mid-frame
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        check("R1 addr after second reset", fetch_addr, 16'h0000);
        {mode_text, mode_hires, mode_page2, mode_store80} = 4'b1000;
        advance(1);
        check("R1 count restarted by reset", fetch_addr, 16'h07E0);

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule